// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Command Sequencer

This block drives the command pins of one SDR SDRAM rank. A host supplies the memory configuration on static inputs and then steps the memory through its power-up procedure one request at a time. The requests are: raise clock enable and wait, close all banks, run a burst of auto-refresh commands, and program the mode register. A busy flag gates each request. After the mode register has been written, an internal timer issues an auto-refresh command each time it runs out. Read and write traffic is handled elsewhere.

The SDRAM clock is the system clock divided by 2 or 3. All command pins change only on the system-clock edge that starts an SDRAM cycle, so each command is held for exactly one SDRAM cycle. Every timing field is given as the cycle count minus one and is counted in SDRAM cycles.

The block checks the configuration and reports whether it is legal. It also reports the capacity that the configuration addresses, in bytes. The refresh reload value comes from the refresh period, which is given in SDRAM cycles. That period is shifted right by the row-address width, and a margin of 20 cycles is then subtracted.

Top module: `sdram_init_refresh_seq`

## Requirements
- R1: `cfg_ok` is 1 only when all of the following hold: clock ratio is 2 or 3, CAS latency is 2 or 3, bank count is 2 or 4, data width is 8, 16 or 32, and row code is 0..2 (row width = code+11). In addition, `cfg_tref >> (11+row code)` must exceed 20.
- R2: `capacity` equals (width/8) × 2^(8+col code) × 2^(11+row code) × banks while `cfg_ok` is 1, and 0 otherwise.
- R3: During and right after reset, `sd_cke`=0, `busy`=0, `sd_ba`=0 and `sd_addr`=0, and {cs_n,ras_n,cas_n,we_n} shows NOP = 0111.
- R4: A request (`req_valid`) takes effect only when `busy`=0 and `cfg_ok`=1. Otherwise it is dropped and no command is issued. An accepted request raises `busy` on the next cycle.
- R5: Command pins change only at SDRAM-cycle starts, which come every `cfg_clk_div` system cycles. A non-NOP command is held for exactly one SDRAM cycle.
- R6: Request code 0 (clock enable) raises `sd_cke`, leaves the pins at NOP, and keeps `busy` for `req_arg`+1 SDRAM cycles counted from the rise of `sd_cke`.
- R7: Request code 1 issues precharge-all: pins 0010, `sd_addr` = only bit 10 set, `sd_ba`=0. `busy` then falls `cfg_trp_m1`+1 SDRAM cycles after the command.
- R8: Request code 2 issues `req_arg`+1 auto-refresh commands (pins 0001), spaced `cfg_trc_m1`+1 SDRAM cycles apart. `busy` falls `cfg_trc_m1`+1 SDRAM cycles after the last one.
- R9: Request code 3 issues load-mode: pins 0000 and `sd_ba`=0. `sd_addr` holds the mode word: bits[2:0]=000 (burst length 1), bit3=0 (sequential), bits[6:4]=CAS latency, bits[8:7]=00 (standard operation), bit9=1 (single-location write burst), and all other bits 0. `busy` falls `cfg_tmrd_m1`+1 SDRAM cycles after the command.
- R10: The pins show NOP between any two commands, and `busy` is 1 whenever a non-NOP command is on the pins.
- R11: Once load-mode has been issued, auto-refresh commands repeat every reload+1 SDRAM cycles, where reload = (`cfg_tref` >> (11+row code)) − 20. `busy` is 1 while a refresh is pending or in progress.
- R12: Once `sd_cke` has risen, it stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_clk_div | input | 2 | System-to-SDRAM clock ratio (2 or 3) |
| cfg_cas | input | 2 | CAS latency (2 or 3) |
| cfg_banks | input | 3 | Internal bank count (2 or 4) |
| cfg_width | input | 6 | Data width in bits (8, 16, 32) |
| cfg_row_code | input | 2 | Row address width minus 11 |
| cfg_col_code | input | 2 | Column address width minus 8 |
| cfg_trp_m1 | input | TW | Precharge period minus one |
| cfg_trc_m1 | input | TW | Refresh-to-next period minus one |
| cfg_tmrd_m1 | input | TW | Mode-load period minus one |
| cfg_tref | input | TREF_W | Full refresh period in SDRAM cycles |
| req_valid | input | 1 | Command request strobe |
| req_cmd | input | 2 | 0 clock enable, 1 precharge-all, 2 auto-refresh, 3 load-mode |
| req_arg | input | ARG_W | Delay minus one (code 0) or refresh count minus one (code 2) |
| busy | output | 1 | Request or refresh in progress |
| cfg_ok | output | 1 | Configuration legal |
| capacity | output | CAP_W | Addressable bytes |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | ADDR_W | Address bus |

## Verification
The refresh timer is the hardest part to reach from the ports. It starts only after a complete power-up procedure has written the mode register, and it fires at an interval derived from a shifted period. The bench therefore runs the full request sequence for every combination of clock ratio, CAS latency and two row widths. It picks refresh periods that give a reload of about a dozen cycles, so the timer expires several times within a short window. The ignored-request case is reached by pulsing a second request inside the precharge wait and by pulsing one while the configuration is illegal.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;

  typedef enum logic [1:0] {
    HC_CKE  = 2'd0,
    HC_PALL = 2'd1,
    HC_AREF = 2'd2,
    HC_LMR  = 2'd3
  } host_cmd_e;

  typedef enum logic {SQ_IDLE, SQ_WAIT} seq_state_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] PIN_NOP  = 4'b0111;
  localparam logic [3:0] PIN_PALL = 4'b0010;
  localparam logic [3:0] PIN_AREF = 4'b0001;
  localparam logic [3:0] PIN_LMR  = 4'b0000;

  // Mode word: burst 1, sequential, CAS latency, standard, single write burst
  function automatic logic [10:0] mode_word(input logic [1:0] cas);
    logic [10:0] w;
    w      = '0;
    w[6:4] = {1'b0, cas};
    w[9]   = 1'b1;
    return w;
  endfunction

  function automatic logic shape_legal(input logic [1:0] div, input logic [1:0] cas,
                                       input logic [2:0] banks, input logic [5:0] width,
                                       input logic [1:0] row);
    logic d_ok, c_ok, b_ok, w_ok, r_ok;
    d_ok = (div == 2'd2) || (div == 2'd3);
    c_ok = (cas == 2'd2) || (cas == 2'd3);
    b_ok = (banks == 3'd2) || (banks == 3'd4);
    w_ok = (width == 6'd8) || (width == 6'd16) || (width == 6'd32);
    r_ok = (row <= 2'd2);
    return d_ok && c_ok && b_ok && w_ok && r_ok;
  endfunction

  // log2 of capacity in bytes
  function automatic logic [4:0] cap_shift(input logic [5:0] width, input logic [2:0] banks,
                                           input logic [1:0] row, input logic [1:0] col);
    logic [4:0] s;
    s = 5'd19 + {3'b000, row} + {3'b000, col};
    if (width == 6'd16)      s = s + 5'd1;
    else if (width == 6'd32) s = s + 5'd2;
    s = s + ((banks == 3'd4) ? 5'd2 : 5'd1);
    return s;
  endfunction

  // Period per row in SDRAM cycles
  function automatic logic [31:0] per_row(input logic [31:0] tref, input logic [1:0] row);
    return tref >> (5'd11 + {3'b000, row});
  endfunction

endpackage

// File: rtl/sdseq_tick.sv
module sdseq_tick (
  input  logic clk,
  input  logic rst_n,
  input  logic div3,
  output logic tick
);
  logic [1:0] cnt;
  logic [1:0] last;

  assign last = div3 ? 2'd2 : 2'd1;
  assign tick = (cnt == 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (tick)  cnt <= last;
    else            cnt <= cnt - 2'd1;
  end

  // R5: SDRAM cycle starts are never back to back
  p_tick_gap_r5: assert property (@(posedge clk) disable iff (!rst_n) tick |=> !tick);

endmodule

// File: rtl/sdseq_cfg_check.sv
module sdseq_cfg_check
  import sdseq_pkg::*;
#(
  parameter int TREF_W = 24,
  parameter int CAP_W  = 29
) (
  input  logic [1:0]        div,
  input  logic [1:0]        cas,
  input  logic [2:0]        banks,
  input  logic [5:0]        width,
  input  logic [1:0]        row,
  input  logic [1:0]        col,
  input  logic [TREF_W-1:0] tref,
  output logic              ok,
  output logic [TREF_W-1:0] reload,
  output logic [CAP_W-1:0]  capacity
);
  logic [31:0] base;
  logic        long_enough;

  always_comb begin
    base        = per_row(32'(tref), row);
    long_enough = base > 32'd20;
    ok          = shape_legal(div, cas, banks, width, row) && long_enough;
    reload      = TREF_W'(base - 32'd20);
    capacity    = ok ? (CAP_W'(1) << cap_shift(width, banks, row, col)) : '0;
  end

endmodule

// File: rtl/sdseq_ref_timer.sv
module sdseq_ref_timer #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  logic [CNT_W-1:0] reload,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;

  assign expire = en && tick && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!en)    cnt <= reload;
    else if (tick)   cnt <= (cnt == '0) ? reload : cnt - 1'b1;
  end

  // R11: legal reload is at least 1, so expiries never come on consecutive cycles
  p_expire_gap_r11: assert property (@(posedge clk) disable iff (!rst_n) expire |=> !expire);

endmodule

// File: rtl/sdram_init_refresh_seq.sv
module sdram_init_refresh_seq
  import sdseq_pkg::*;
#(
  parameter int TW     = 4,
  parameter int ARG_W  = 16,
  parameter int TREF_W = 24,
  parameter int ADDR_W = 13,
  parameter int CAP_W  = 29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_clk_div,
  input  logic [1:0]        cfg_cas,
  input  logic [2:0]        cfg_banks,
  input  logic [5:0]        cfg_width,
  input  logic [1:0]        cfg_row_code,
  input  logic [1:0]        cfg_col_code,
  input  logic [TW-1:0]     cfg_trp_m1,
  input  logic [TW-1:0]     cfg_trc_m1,
  input  logic [TW-1:0]     cfg_tmrd_m1,
  input  logic [TREF_W-1:0] cfg_tref,
  input  logic              req_valid,
  input  logic [1:0]        req_cmd,
  input  logic [ARG_W-1:0]  req_arg,
  output logic              busy,
  output logic              cfg_ok,
  output logic [CAP_W-1:0]  capacity,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [1:0]        sd_ba,
  output logic [ADDR_W-1:0] sd_addr
);
  localparam logic [ADDR_W-1:0] PALL_ADDR = ADDR_W'(11'h400);

  // Named internal events
  logic              tick;
  logic              ref_expire;
  logic              accept;
  logic [TREF_W-1:0] reload;

  seq_state_e        state;
  logic [ARG_W-1:0]  wcnt, ar_left, job_arg;
  logic              job_v, ref_pend, init_done, cke_q;
  host_cmd_e         job_cmd;
  logic [3:0]        pins_q;
  logic [1:0]        ba_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ARG_W-1:0]  trc_w;

  sdseq_tick u_tick (
    .clk(clk), .rst_n(rst_n), .div3(cfg_clk_div == 2'd3), .tick(tick)
  );

  sdseq_cfg_check #(.TREF_W(TREF_W), .CAP_W(CAP_W)) u_cfg (
    .div(cfg_clk_div), .cas(cfg_cas), .banks(cfg_banks), .width(cfg_width),
    .row(cfg_row_code), .col(cfg_col_code), .tref(cfg_tref),
    .ok(cfg_ok), .reload(reload), .capacity(capacity)
  );

  sdseq_ref_timer #(.CNT_W(TREF_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(init_done && cfg_ok),
    .reload(reload), .expire(ref_expire)
  );

  assign busy   = job_v || ref_pend || (state == SQ_WAIT);
  assign accept = req_valid && !busy && cfg_ok;
  assign trc_w  = ARG_W'(cfg_trc_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      wcnt      <= '0;
      ar_left   <= '0;
      job_v     <= 1'b0;
      job_cmd   <= HC_CKE;
      job_arg   <= '0;
      ref_pend  <= 1'b0;
      init_done <= 1'b0;
      cke_q     <= 1'b0;
      pins_q    <= PIN_NOP;
      ba_q      <= '0;
      addr_q    <= '0;
    end else begin
      if (accept) begin
        job_v   <= 1'b1;
        job_cmd <= host_cmd_e'(req_cmd);
        job_arg <= req_arg;
      end
      if (tick) begin
        pins_q <= PIN_NOP;
        addr_q <= '0;
        ba_q   <= '0;
        if (state == SQ_IDLE) begin
          if (job_v) begin
            job_v   <= 1'b0;
            state   <= SQ_WAIT;
            ar_left <= '0;
            case (job_cmd)
              HC_CKE: begin
                cke_q <= 1'b1;
                wcnt  <= job_arg;
              end
              HC_PALL: begin
                pins_q <= PIN_PALL;
                addr_q <= PALL_ADDR;
                wcnt   <= ARG_W'(cfg_trp_m1);
              end
              HC_AREF: begin
                pins_q  <= PIN_AREF;
                wcnt    <= trc_w;
                ar_left <= job_arg;
              end
              default: begin
                pins_q    <= PIN_LMR;
                addr_q    <= ADDR_W'(mode_word(cfg_cas));
                wcnt      <= ARG_W'(cfg_tmrd_m1);
                init_done <= 1'b1;
              end
            endcase
          end else if (ref_pend) begin
            ref_pend <= 1'b0;
            state    <= SQ_WAIT;
            pins_q   <= PIN_AREF;
            wcnt     <= trc_w;
            ar_left  <= '0;
          end
        end else begin
          if (wcnt != '0) begin
            wcnt <= wcnt - 1'b1;
          end else if (ar_left != '0) begin
            ar_left <= ar_left - 1'b1;
            pins_q  <= PIN_AREF;
            wcnt    <= trc_w;
          end else begin
            state <= SQ_IDLE;
          end
        end
      end
      if (ref_expire) ref_pend <= 1'b1;
    end
  end

  assign sd_cke = cke_q;
  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = pins_q;
  assign sd_ba   = ba_q;
  assign sd_addr = addr_q;

  // R4: an accepted request is reflected in busy on the next cycle
  p_accept_busy_r4: assert property (@(posedge clk) disable iff (!rst_n) accept |=> busy);
  // R10: a command on the pins is always covered by busy
  p_cmd_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pins_q != PIN_NOP) |-> busy);
  // R5: pins only move on an SDRAM cycle start
  p_pins_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pins_q));
  // R12: clock enable never drops once raised
  p_cke_hold_r12: assert property (@(posedge clk) disable iff (!rst_n) sd_cke |=> sd_cke);

endmodule

// File: tb/sdram_init_refresh_seq_test.sv
`timescale 1ns/1ps
module sdram_init_refresh_seq_test;
  localparam int TW = 4, ARG_W = 16, TREF_W = 24, ADDR_W = 13, CAP_W = 29;
  localparam logic [3:0] P_NOP = 4'b0111;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg_clk_div = 2'd2, cfg_cas = 2'd2, cfg_row_code = 2'd0, cfg_col_code = 2'd0;
  logic [2:0] cfg_banks = 3'd4;
  logic [5:0] cfg_width = 6'd16;
  logic [TW-1:0] cfg_trp_m1 = 1, cfg_trc_m1 = 1, cfg_tmrd_m1 = 1;
  logic [TREF_W-1:0] cfg_tref = '1;
  logic req_valid = 1'b0;
  logic [1:0] req_cmd = 2'd0;
  logic [ARG_W-1:0] req_arg = '0;
  logic busy, cfg_ok, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [CAP_W-1:0] capacity;
  logic [1:0] sd_ba;
  logic [ADDR_W-1:0] sd_addr;

  sdram_init_refresh_seq #(.TW(TW), .ARG_W(ARG_W), .TREF_W(TREF_W), .ADDR_W(ADDR_W), .CAP_W(CAP_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_clk_div(cfg_clk_div), .cfg_cas(cfg_cas),
    .cfg_banks(cfg_banks), .cfg_width(cfg_width), .cfg_row_code(cfg_row_code),
    .cfg_col_code(cfg_col_code), .cfg_trp_m1(cfg_trp_m1), .cfg_trc_m1(cfg_trc_m1),
    .cfg_tmrd_m1(cfg_tmrd_m1), .cfg_tref(cfg_tref), .req_valid(req_valid),
    .req_cmd(req_cmd), .req_arg(req_arg), .busy(busy), .cfg_ok(cfg_ok),
    .capacity(capacity), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Pin monitor
  logic [3:0] ev_cmd [64];
  int         ev_cyc [64];
  logic [ADDR_W-1:0] ev_addr [64];
  logic [1:0] ev_ba [64];
  bit         ev_busy [64];
  int ev_n = 0, bad_trans = 0, hold_bad = 0, start_cyc = 0, div_exp = 2;
  int cke_cyc = 0, bfall_cyc = 0;
  logic [3:0] prev_pins = P_NOP, pins;
  logic prev_cke = 0, prev_busy = 0;

  always @(negedge clk) begin
    pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    if (!rst_n) begin
      prev_pins = P_NOP; prev_cke = 0; prev_busy = 0;
    end else begin
      if (pins != prev_pins) begin
        if (pins != P_NOP) begin
          if (prev_pins != P_NOP) bad_trans++;
          start_cyc = cyc;
          if (ev_n < 64) begin
            ev_cmd[ev_n] = pins; ev_cyc[ev_n] = cyc; ev_addr[ev_n] = sd_addr;
            ev_ba[ev_n] = sd_ba; ev_busy[ev_n] = busy;
          end
          ev_n++;
        end else if (cyc - start_cyc != div_exp) hold_bad++;
      end
      if (sd_cke && !prev_cke) cke_cyc = cyc;
      if (!busy && prev_busy) bfall_cyc = cyc;
      prev_pins = pins; prev_cke = sd_cke; prev_busy = busy;
    end
  end

  task automatic pulse(input logic [1:0] c, input int a);
    @(negedge clk);
    req_valid = 1'b1; req_cmd = c; req_arg = ARG_W'(a);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
    #1;
  endtask

  task automatic run_cfg(input int div, input int cas, input int row, input bit first);
    int trp, trc, tmrd, d, rl, n0;
    trp = (div + cas) % 3; trc = 1 + row; tmrd = cas - 1; d = 2 + row;
    rl = 12;
    rst_n = 0;
    cfg_clk_div = 2'(div); cfg_cas = 2'(cas); cfg_row_code = 2'(row);
    cfg_banks = 3'd4; cfg_width = 6'd16; cfg_col_code = 2'd1;
    cfg_trp_m1 = TW'(trp); cfg_trc_m1 = TW'(trc); cfg_tmrd_m1 = TW'(tmrd);
    cfg_tref = TREF_W'(((20 + rl) << (11 + row)) + 5);
    div_exp = div;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(sd_cke == 0 && busy == 0, "R3 cke/busy", {sd_cke, busy}, 0);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == P_NOP, "R3 pins",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, P_NOP);
    chk(sd_addr == 0 && sd_ba == 0, "R3 addr", sd_addr, 0);
    ev_n = 0;
    if (first) begin
      cfg_cas = 2'd1; #1;
      chk(cfg_ok == 0, "R4 illegal cfg_ok", cfg_ok, 0);
      pulse(2'd1, 0);
      repeat (12) @(negedge clk); #1;
      chk(ev_n == 0 && busy == 0, "R4 illegal cfg request dropped", ev_n, 0);
      cfg_cas = 2'(cas); #1;
    end
    chk(cfg_ok == 1, "R1 run cfg legal", cfg_ok, 1);
    // clock enable
    pulse(2'd0, d); wait_idle();
    chk(sd_cke == 1, "R6 cke", sd_cke, 1);
    chk(bfall_cyc - cke_cyc == (d + 1) * div, "R6 delay", bfall_cyc - cke_cyc, (d + 1) * div);
    chk(ev_n == 0, "R6 no command", ev_n, 0);
    // precharge-all with a second request inside its wait
    pulse(2'd1, 0);
    pulse(2'd3, 0);
    wait_idle();
    chk(ev_n == 1, "R4 busy request dropped", ev_n, 1);
    chk(ev_cmd[0] == 4'b0010, "R7 pins", ev_cmd[0], 4'b0010);
    chk(ev_addr[0] == 13'h400 && ev_ba[0] == 0, "R7 addr", ev_addr[0], 13'h400);
    chk(bfall_cyc - ev_cyc[0] == (trp + 1) * div, "R7 wait", bfall_cyc - ev_cyc[0], (trp + 1) * div);
    // auto-refresh burst of 3
    pulse(2'd2, 2); wait_idle();
    chk(ev_n == 4, "R8 count", ev_n, 4);
    for (int k = 1; k <= 3; k++) begin
      chk(ev_cmd[k] == 4'b0001, "R8 pins", ev_cmd[k], 4'b0001);
      if (k > 1) chk(ev_cyc[k] - ev_cyc[k-1] == (trc + 1) * div, "R8 spacing",
                     ev_cyc[k] - ev_cyc[k-1], (trc + 1) * div);
    end
    chk(bfall_cyc - ev_cyc[3] == (trc + 1) * div, "R8 wait", bfall_cyc - ev_cyc[3], (trc + 1) * div);
    // load mode
    pulse(2'd3, 0); wait_idle();
    chk(ev_cmd[4] == 4'b0000 && ev_ba[4] == 0, "R9 pins", ev_cmd[4], 0);
    chk(ev_addr[4] == ADDR_W'((1 << 9) | (cas << 4)), "R9 mode word", ev_addr[4], (1 << 9) | (cas << 4));
    chk(bfall_cyc - ev_cyc[4] == (tmrd + 1) * div, "R9 wait", bfall_cyc - ev_cyc[4], (tmrd + 1) * div);
    // periodic refresh
    n0 = 5;
    for (int i = 0; i < 3000 && ev_n < n0 + 4; i++) @(negedge clk);
    #1;
    chk(ev_n >= n0 + 4, "R11 refreshes seen", ev_n, n0 + 4);
    for (int k = n0; k < n0 + 4; k++) begin
      chk(ev_cmd[k] == 4'b0001 && ev_busy[k], "R11 refresh pins/busy", ev_cmd[k], 1);
      if (k > n0) chk(ev_cyc[k] - ev_cyc[k-1] == (rl + 1) * div, "R11 interval",
                      ev_cyc[k] - ev_cyc[k-1], (rl + 1) * div);
    end
    chk(bad_trans == 0, "R10 NOP between commands", bad_trans, 0);
    chk(hold_bad == 0, "R5 command hold", hold_bad, 0);
    chk(sd_cke == 1, "R12 cke held", sd_cke, 1);
  endtask

  initial begin
    bit eok;
    longint ecap;
    // R1/R2 sweep of the configuration checker
    cfg_tref = '1;
    for (int dv = 0; dv < 4; dv++)
      for (int cs = 0; cs < 4; cs++)
        for (int bk = 0; bk < 8; bk++)
          for (int w = 0; w <= 36; w += 4)
            for (int rw = 0; rw < 4; rw++)
              for (int cl = 0; cl < 4; cl++) begin
                cfg_clk_div = 2'(dv); cfg_cas = 2'(cs); cfg_banks = 3'(bk);
                cfg_width = 6'(w); cfg_row_code = 2'(rw); cfg_col_code = 2'(cl);
                #1;
                eok = (dv >= 2) && (cs >= 2) && (bk == 2 || bk == 4) &&
                      (w == 8 || w == 16 || w == 32) && (rw < 3);
                ecap = eok ? longint'(w / 8) * (longint'(256) << cl) * (longint'(2048) << rw) * bk : 0;
                chk(cfg_ok == eok, "R1 legality", cfg_ok, eok);
                chk(capacity == ecap, "R2 capacity", capacity, ecap);
              end
    cfg_clk_div = 2'd2; cfg_cas = 2'd2; cfg_banks = 3'd2; cfg_width = 6'd8; cfg_col_code = 2'd0;
    for (int rw = 0; rw < 3; rw += 2) begin
      cfg_row_code = 2'(rw);
      cfg_tref = TREF_W'(21 << (11 + rw)); #1;
      chk(cfg_ok == 1, "R1 refresh margin ok", cfg_ok, 1);
      cfg_tref = TREF_W'((21 << (11 + rw)) - 1); #1;
      chk(cfg_ok == 0, "R1 refresh margin short", cfg_ok, 0);
    end
    for (int dv = 2; dv <= 3; dv++)
      for (int cs = 2; cs <= 3; cs++)
        for (int rw = 0; rw <= 1; rw++)
          run_cfg(dv, cs, rw, (dv == 2 && cs == 2 && rw == 0));
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule